// File: doc/BRIEF.md
# Thread-Aware Branch Target Buffer

This block is a direct-mapped table of predicted branch targets shared by several hardware threads. A fetch stage presents an instruction address and the thread that owns it on the lookup port. One clock later it gets a hit flag and the stored target. A branch resolution stage writes the resolved target for an address and thread through the update port. A synchronous flush input, and the asynchronous reset, invalidate the whole table.

The set index comes from the address bits just above the instruction-offset field. The thread number is XORed into the top bits of that index. The tag is the field of address bits above the index, of a parameterized width. An entry remembers which thread wrote it, so two threads whose addresses land on one entry cannot use each other's targets. Entry count, tag width, offset shift, thread count, address width and target width are parameters. An entry count that is not a power of two stops elaboration.

Top module: `btb_mt`

## Requirements
- R1: During and after reset, rspValid, rspHit and rspTarget are 0, and every entry is invalid, so the first lookups after reset miss.
- R2: rspValid is high in exactly the cycles that follow a cycle with lkValid high. When lkValid was low, rspHit and rspTarget are 0 in the next cycle.
- R3: A lookup hits only when the indexed entry is valid, the entry's stored tag equals the lookup tag, and the entry's stored thread equals lkTid. On a hit, rspTarget is the stored target.
- R4: A lookup that misses returns rspHit = 0 and rspTarget = 0.
- R5: The index is lkPc[SHIFT+IDX_W-1:SHIFT] XOR (tid << (IDX_W - log2(THREADS))), where IDX_W = log2(ENTRIES). Address bits below SHIFT do not affect the result. With the defaults (16 entries, SHIFT 2, 2 threads) this is PC[5:2] with tid XORed into bit 3.
- R6: The tag is PC[SHIFT+IDX_W+TAG_W-1 : SHIFT+IDX_W]. Address bits above it do not take part in the compare. With the defaults (TAG_W 6) this is PC[11:6].
- R7: An update with upValid high and flush low writes the indexed entry whatever it held before. It sets the entry valid and stores the tag, the thread and upTarget.
- R8: A lookup and an update in the same cycle to the same entry give the lookup the entry's contents from before the update. Lookups in later cycles see the new contents.
- R9: flush high invalidates every entry at the next edge. An update in the same cycle is dropped, and a lookup in the same cycle misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup request |
| lkPc | input | ADDR_W | Lookup instruction address |
| lkTid | input | TID_W | Lookup thread number |
| upValid | input | 1 | Update request |
| upPc | input | ADDR_W | Update branch address |
| upTid | input | TID_W | Update thread number |
| upTarget | input | TGT_W | Resolved target to store |
| flush | input | 1 | Invalidate all entries |
| rspValid | output | 1 | Lookup response present |
| rspHit | output | 1 | Lookup hit |
| rspTarget | output | TGT_W | Predicted target, 0 on a miss |

## Verification
A wrong valid bit, tag or thread field in an entry shows up as a wrong hit flag on the very next lookup that indexes that entry. A wrong target field shows up on the next lookup that hits that entry. In both cases the error reaches the ports one cycle after that lookup. An index or tag slice that is off by a bit shows up as aliasing that should not happen, or as a miss where a hit is due. The bench exposes these with pairs of addresses that differ only in the thread-mixed index bit, in a tag bit, in a bit below the offset or in a bit above the tag. A late invalidation, or write-before-read ordering, corrupts the response in the cycle right after the flush or after the colliding update.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic rdEn;    // lookup this cycle
    logic rdKill;  // force the lookup to miss
    logic wrEn;    // write the update entry
    logic clrAll;  // invalidate all entries
  } btbStrobe_t;
endpackage

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 6,
  parameter int SHIFT   = 2,
  parameter int THREADS = 2,
  parameter int ADDR_W  = 32,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int THR_LOG2 = $clog2(THREADS),
  localparam int TID_W    = (THR_LOG2 > 0) ? THR_LOG2 : 1,
  localparam int TAG_SH   = SHIFT + IDX_W
) (
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkPc,
  input  logic [TID_W-1:0]  lkTid,
  input  logic              upValid,
  input  logic [ADDR_W-1:0] upPc,
  input  logic [TID_W-1:0]  upTid,
  input  logic              flush,
  output btbStrobe_t        strobe,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [TAG_W-1:0]  rdTag,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [TAG_W-1:0]  wrTag
);
  logic [IDX_W-1:0] lkMix, upMix;

  generate
    if ((1 << IDX_W) != ENTRIES) begin : g_badEntries
      $error("btb_ctrl: ENTRIES must be a power of two");
    end
    if (THR_LOG2 > IDX_W) begin : g_badThreads
      $error("btb_ctrl: too many threads for the index width");
    end
    if (TAG_SH + TAG_W > ADDR_W) begin : g_badTag
      $error("btb_ctrl: tag field exceeds the address width");
    end
    if (THR_LOG2 == 0) begin : g_oneThread
      assign lkMix = '0;
      assign upMix = '0;
    end else begin : g_multiThread
      assign lkMix = IDX_W'(lkTid) << (IDX_W - THR_LOG2);
      assign upMix = IDX_W'(upTid) << (IDX_W - THR_LOG2);
    end
  endgenerate

  assign rdIdx = lkPc[SHIFT +: IDX_W] ^ lkMix;
  assign wrIdx = upPc[SHIFT +: IDX_W] ^ upMix;
  assign rdTag = lkPc[TAG_SH +: TAG_W];
  assign wrTag = upPc[TAG_SH +: TAG_W];

  always_comb begin
    strobe.rdEn   = lkValid;
    strobe.rdKill = lkValid & flush;
    strobe.wrEn   = upValid & ~flush;
    strobe.clrAll = flush;
  end
endmodule

// File: rtl/btb_data.sv
module btb_data
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 6,
  parameter int TID_W   = 1,
  parameter int TGT_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  btbStrobe_t       strobe,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [TAG_W-1:0] rdTag,
  input  logic [TID_W-1:0] rdTid,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [TAG_W-1:0] wrTag,
  input  logic [TID_W-1:0] wrTid,
  input  logic [TGT_W-1:0] wrTarget,
  output logic             rspValid,
  output logic             rspHit,
  output logic [TGT_W-1:0] rspTarget
);
  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagMem [ENTRIES];
  logic [TID_W-1:0]   tidMem [ENTRIES];
  logic [TGT_W-1:0]   tgtMem [ENTRIES];
  logic               hitNow;

  assign hitNow = strobe.rdEn && !strobe.rdKill && validQ[rdIdx]
                  && (tagMem[rdIdx] == rdTag) && (tidMem[rdIdx] == rdTid);

  // Valid bits and response registers are reset; fields are not
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ    <= '0;
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspTarget <= '0;
    end else begin
      rspValid  <= strobe.rdEn;
      rspHit    <= hitNow;
      rspTarget <= hitNow ? tgtMem[rdIdx] : '0;
      if (strobe.clrAll) validQ <= '0;
      else if (strobe.wrEn) validQ[wrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      tagMem[wrIdx] <= wrTag;
      tidMem[wrIdx] <= wrTid;
      tgtMem[wrIdx] <= wrTarget;
    end
  end
endmodule

// File: rtl/btb_mt.sv
module btb_mt
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 6,
  parameter int SHIFT   = 2,
  parameter int THREADS = 2,
  parameter int ADDR_W  = 32,
  parameter int TGT_W   = 32,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int THR_LOG2 = $clog2(THREADS),
  localparam int TID_W    = (THR_LOG2 > 0) ? THR_LOG2 : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkPc,
  input  logic [TID_W-1:0]  lkTid,
  input  logic              upValid,
  input  logic [ADDR_W-1:0] upPc,
  input  logic [TID_W-1:0]  upTid,
  input  logic [TGT_W-1:0]  upTarget,
  input  logic              flush,
  output logic              rspValid,
  output logic              rspHit,
  output logic [TGT_W-1:0]  rspTarget
);
  btbStrobe_t       strobe;
  logic [IDX_W-1:0] rdIdx, wrIdx;
  logic [TAG_W-1:0] rdTag, wrTag;

  btb_ctrl #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .SHIFT(SHIFT),
    .THREADS(THREADS), .ADDR_W(ADDR_W)
  ) ctrl (
    .lkValid(lkValid), .lkPc(lkPc), .lkTid(lkTid),
    .upValid(upValid), .upPc(upPc), .upTid(upTid),
    .flush(flush), .strobe(strobe),
    .rdIdx(rdIdx), .rdTag(rdTag), .wrIdx(wrIdx), .wrTag(wrTag)
  );

  btb_data #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .TID_W(TID_W), .TGT_W(TGT_W)
  ) data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rdIdx(rdIdx), .rdTag(rdTag), .rdTid(lkTid),
    .wrIdx(wrIdx), .wrTag(wrTag), .wrTid(upTid), .wrTarget(upTarget),
    .rspValid(rspValid), .rspHit(rspHit), .rspTarget(rspTarget)
  );
endmodule

// File: rtl/btb_mt_chk.sv
module btb_mt_chk #(
  parameter int TGT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             lkValid,
  input logic             flush,
  input logic             rspValid,
  input logic             rspHit,
  input logic [TGT_W-1:0] rspTarget
);
  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspHit |-> rspTarget == '0);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> (!rspValid && !rspHit));

  // R9
  flush_same_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flush && lkValid) |=> !rspHit);

  // R9
  flush_next_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush ##1 lkValid |=> !rspHit);
endmodule

bind btb_mt btb_mt_chk #(.TGT_W(TGT_W)) chk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .flush(flush),
  .rspValid(rspValid), .rspHit(rspHit), .rspTarget(rspTarget)
);

// File: tb/btb_mt_test.sv
module btb_mt_test;
  localparam int ENTRIES = 16, TAG_W = 6, SHIFT = 2, THREADS = 2;
  localparam int ADDR_W = 32, TGT_W = 32, IDX_W = 4, TID_W = 1;

  logic clk = 0, rstN = 0;
  logic lkValid = 0, upValid = 0, flush = 0;
  logic [ADDR_W-1:0] lkPc = '0, upPc = '0;
  logic [TID_W-1:0] lkTid = '0, upTid = '0;
  logic [TGT_W-1:0] upTarget = '0;
  logic rspValid, rspHit;
  logic [TGT_W-1:0] rspTarget;

  int checks = 0, failures = 0;
  bit done = 0;

  bit mValid [ENTRIES];
  logic [TAG_W-1:0] mTag [ENTRIES];
  logic [TID_W-1:0] mTid [ENTRIES];
  logic [TGT_W-1:0] mTgt [ENTRIES];

  always #5 clk = ~clk;

  btb_mt #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .SHIFT(SHIFT), .THREADS(THREADS),
           .ADDR_W(ADDR_W), .TGT_W(TGT_W)) uut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkPc(lkPc), .lkTid(lkTid),
    .upValid(upValid), .upPc(upPc), .upTid(upTid), .upTarget(upTarget),
    .flush(flush), .rspValid(rspValid), .rspHit(rspHit), .rspTarget(rspTarget));

  function automatic int idxOf(logic [ADDR_W-1:0] pc, logic [TID_W-1:0] tid);
    return int'(((pc >> SHIFT) ^ (ADDR_W'(tid) << (IDX_W - 1))) & (ENTRIES - 1));
  endfunction

  function automatic logic [TAG_W-1:0] tagOf(logic [ADDR_W-1:0] pc);
    return TAG_W'(pc >> (SHIFT + IDX_W));
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare the response at the next negedge
  task automatic step(bit lk, logic [ADDR_W-1:0] lpc, logic [TID_W-1:0] ltid,
                      bit up, logic [ADDR_W-1:0] upc, logic [TID_W-1:0] utid,
                      logic [TGT_W-1:0] utgt, bit fl, string req);
    int li = idxOf(lpc, ltid);
    int ui = idxOf(upc, utid);
    bit eHit = lk && !fl && mValid[li] && mTag[li] == tagOf(lpc) && mTid[li] == ltid;
    logic [TGT_W-1:0] eTgt = eHit ? mTgt[li] : '0;
    if (fl) begin
      for (int i = 0; i < ENTRIES; i++) mValid[i] = 0;
    end else if (up) begin
      mValid[ui] = 1; mTag[ui] = tagOf(upc); mTid[ui] = utid; mTgt[ui] = utgt;
    end
    lkValid = lk; lkPc = lpc; lkTid = ltid;
    upValid = up; upPc = upc; upTid = utid; upTarget = utgt; flush = fl;
    @(posedge clk);
    @(negedge clk);
    check(rspValid == lk, {req, " rspValid (R2)"}, 64'(rspValid), 64'(lk));
    check(rspHit == eHit, {req, " hit"}, 64'(rspHit), 64'(eHit));
    check(rspTarget == eTgt, {req, " target"}, 64'(rspTarget), 64'(eTgt));
  endtask

  task automatic look(logic [ADDR_W-1:0] pc, logic [TID_W-1:0] tid, string req);
    step(1, pc, tid, 0, '0, '0, '0, 0, req);
  endtask

  task automatic upd(logic [ADDR_W-1:0] pc, logic [TID_W-1:0] tid,
                     logic [TGT_W-1:0] tgt, string req);
    step(0, '0, '0, 1, pc, tid, tgt, 0, req);
  endtask

  initial begin
    logic [ADDR_W-1:0] a;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < ENTRIES; i++) mValid[i] = 0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(!rspValid && !rspHit && rspTarget == '0, "R1 reset outputs",
          64'({rspValid, rspHit}), 64'(0));
    rstN = 1;
    @(negedge clk);
    a = 32'h0000_0154;                       // index 5, tag 5
    look(a, 0, "R1 empty after reset");
    upd(a, 0, 32'hCAFE_0001, "R7 first write");
    look(a, 0, "R3 own thread hit");
    look(a, 1, "R5 other thread other index");
    look(a ^ 32'h20, 1, "R3 same entry other thread");
    look(a + 32'h40, 0, "R6 tag mismatch");
    look(a | 32'h3, 0, "R5 offset bits ignored");
    look(a | 32'h0010_0000, 0, "R6 bits above tag ignored");
    upd(a ^ 32'h20, 1, 32'hBEEF_0002, "R7 overwrite by other thread");
    look(a, 0, "R7 old occupant gone");
    look(a ^ 32'h20, 1, "R7 new occupant hits");
    step(1, a, 0, 1, a, 0, 32'h1234_5678, 0, "R8 read before write");
    look(a, 0, "R8 write visible next cycle");
    look(a + 32'h4, 1, "R4 miss returns zero");
    step(1, a, 0, 1, a + 32'h8, 0, 32'h7777, 1, "R9 flush with update");
    look(a, 0, "R9 entry cleared");
    look(a + 32'h8, 0, "R9 same-cycle update dropped");
    step(0, '0, 0, 0, '0, 0, '0, 0, "R2 idle");
    // Random mix: R2 R3 R4 R7 R8 R9
    for (int n = 0; n < 4000; n++) begin
      logic [ADDR_W-1:0] p1, p2;
      p1 = (($urandom % 4) << 6) | (($urandom % 16) << 2) | ($urandom % 4)
           | (($urandom % 2) << 14);
      p2 = (($urandom % 4) << 6) | (($urandom % 16) << 2);
      step(($urandom % 10) < 7, p1, TID_W'($urandom % 2),
           ($urandom % 10) < 4, p2, TID_W'($urandom % 2), $urandom,
           ($urandom % 200) == 0, "R3 random");
    end
    lkValid = 0; upValid = 0; flush = 0;
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule